// File: doc/BRIEF.md
# Integer PLL Divider Reprogramming Sequencer

This block is the control engine that moves an integer PLL from one set of divider settings to another without handing a half-configured clock to the logic downstream. A request carries four divider values: reference divide, output divide, feedback multiply and bandwidth. The sequencer owns the divider registers that feed the PLL. For each request it first keeps a copy of the settings in force. If the downstream clock selector is in its normal mode, it moves the selector to the slow reference. It then holds the PLL in reset while the new fields are written, and waits a settling time that grows with the reference divider. After that it polls the lock input, up to a fixed number of attempts.

If lock never arrives, the sequencer repeats the whole procedure once with the saved settings. It finishes with an error indication whether or not that second pass locks. The clock selector goes back to normal mode at the end only if this sequencer was the one that moved it away. The selector itself, the analog PLL and the choice of divider values sit outside the block. The selector mode comes in as a 2-bit readback and goes out as a write strobe with data.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request is accepted only in the idle state. If the selector mode readback `mode_cur` then equals NORMAL (2'd1), the block writes SLOW (2'd0) with a one-cycle `mode_wr` and records that it parked the selector. In any other mode it issues no write.
- R2: `pll_rst` rises before any divider output changes and falls only after all four have been written. Divider outputs never change while `pll_rst` is low.
- R3: Each divider output holds the requested value minus one. The copy of the old settings is read back as each output plus one.
- R4: After `pll_rst` falls, the block waits D = (NR*500)/24 + 1 microseconds, with CYC_PER_US clock cycles per microsecond, before the first lock poll. With `lock` already high, `done` is seen D*CYC_PER_US+3 cycles after the fall when the selector was parked, and D*CYC_PER_US+2 cycles after the fall when it was not.
- R5: Lock is polled once per cycle for at most LOCK_LIMIT attempts. After the last failed attempt, the next `pll_rst` rise follows D*CYC_PER_US+LOCK_LIMIT+2 cycles after the fall.
- R6: On a lock timeout, the full sequence runs again with the saved old divider values, and `err` is reported high with `done`.
- R7: The rollback pass never starts a second rollback. If it also times out, the block finishes with `err` high and the old values left in place. `done` is then seen D*CYC_PER_US+LOCK_LIMIT+2 cycles after the second fall when the selector was parked.
- R8: NORMAL is written back to the selector at the end only if the block parked it for this request. Otherwise no mode write occurs.
- R9: `busy` is high from the cycle after acceptance until `done`. `done` lasts exactly one cycle. Requests made while `busy` is high are ignored.
- R10: After reset, `busy`, `done`, `err`, `mode_wr` and `pll_rst` are low and all divider outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_nr | input | NR_W | Requested reference divider (1 and up) |
| req_no | input | NO_W | Requested output divider (1 and up) |
| req_nf | input | NF_W | Requested feedback multiplier (1 and up) |
| req_nb | input | NB_W | Requested bandwidth value (1 and up) |
| mode_cur | input | 2 | Clock selector mode readback (0 slow, 1 normal, 2 deep) |
| lock | input | 1 | PLL lock indication |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rollback was taken; valid with done |
| mode_wr | output | 1 | Selector mode write strobe |
| mode_wdata | output | 2 | Selector mode to write |
| pll_rst | output | 1 | PLL reset |
| div_nr | output | NR_W | Stored reference divider minus one |
| div_no | output | NO_W | Stored output divider minus one |
| div_nf | output | NF_W | Stored feedback multiplier minus one |
| div_nb | output | NB_W | Stored bandwidth minus one |

## Verification
A wrong sequencer state shows first as a shift in event timing at the ports. A settle timer loaded with the wrong count, or a poll counter with the wrong bound, moves `done` or the rollback's second reset pulse by a fixed number of cycles, and the bench measures that interval exactly from the reset fall. A lost or spurious parked flag shows in the same sequence as a missing or extra selector write. A bad snapshot leaves divider outputs that do not match the old values once the rollback `done` arrives. Divider writes made outside the reset window are flagged on the cycle they happen.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam logic [1:0] MODE_SLOW   = 2'd0;
  localparam logic [1:0] MODE_NORMAL = 2'd1;
  localparam logic [1:0] MODE_DEEP   = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAPT,
    ST_RST_ON,
    ST_LOAD,
    ST_RST_OFF,
    ST_SETTLE,
    ST_POLL,
    ST_UNPARK,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/pllseq_field.sv
module pllseq_field #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         roll,
  input  logic         wr,
  input  logic [W-1:0] req_val,
  output logic [W-1:0] tgt,
  output logic [W-1:0] div_q
);
  logic [W-1:0] tgt_q, tgt_d;
  logic [W-1:0] snap_q, snap_d;
  logic [W-1:0] div_d;

  always_comb begin
    tgt_d  = tgt_q;
    snap_d = snap_q;
    div_d  = div_q;
    if (capture) begin
      tgt_d  = req_val;
      snap_d = div_q + W'(1);
    end else if (roll) begin
      tgt_d = snap_q;
    end
    if (wr) div_d = tgt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      snap_q <= '0;
      div_q  <= '0;
    end else begin
      tgt_q  <= tgt_d;
      snap_q <= snap_d;
      div_q  <= div_d;
    end
  end

  assign tgt = tgt_q;
endmodule

// File: rtl/pllseq_us_timer.sv
module pllseq_us_timer #(
  parameter int CYC_PER_US = 125,
  parameter int US_W       = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] dly_us,
  output logic            expired
);
  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_US - 1);

  logic            run_q, run_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [US_W-1:0]  us_q, us_d;

  always_comb begin
    run_d = run_q;
    pre_d = pre_q;
    us_d  = us_q;
    if (start) begin
      run_d = 1'b1;
      us_d  = dly_us;
      pre_d = PRE_TOP;
    end else if (run_q) begin
      if (us_q == '0) begin
        run_d = 1'b0;
      end else if (pre_q == '0) begin
        pre_d = PRE_TOP;
        us_d  = us_q - US_W'(1);
      end else begin
        pre_d = pre_q - PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      run_q <= run_d;
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end

  assign expired = run_q && (us_q == '0);

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pre_q <= PRE_TOP)) else $error("prescaler out of range"); // R4
endmodule

// File: rtl/pllseq_lock_poll.sv
module pllseq_lock_poll #(
  parameter int LOCK_LIMIT = 24000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic lock,
  output logic hit,
  output logic expire
);
  localparam int CNT_W = $clog2(LOCK_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (active && !lock) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit    = active && lock;
  assign expire = active && !lock && (cnt_q == LAST);

  AST_POLL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LOCK_LIMIT)) else $error("poll count past limit"); // R5
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] mode_cur,
  input  logic       tmr_expired,
  input  logic       poll_hit,
  input  logic       poll_expire,
  output logic       capture,
  output logic       roll,
  output logic       wr,
  output logic       tmr_start,
  output logic       poll_clr,
  output logic       poll_active,
  output logic       mode_wr,
  output logic [1:0] mode_wdata,
  output logic       pll_rst,
  output logic       busy,
  output logic       done,
  output logic       err
);
  seq_state_e st_q, st_d;
  logic parked_q, parked_d;
  logic rb_q, rb_d;
  logic err_q, err_d;
  logic rst_q, rst_d;

  always_comb begin
    st_d        = st_q;
    parked_d    = parked_q;
    rb_d        = rb_q;
    err_d       = err_q;
    rst_d       = rst_q;
    capture     = 1'b0;
    roll        = 1'b0;
    wr          = 1'b0;
    tmr_start   = 1'b0;
    poll_clr    = 1'b0;
    poll_active = 1'b0;
    mode_wr     = 1'b0;
    mode_wdata  = MODE_SLOW;
    done        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          capture  = 1'b1;
          parked_d = 1'b0;
          rb_d     = 1'b0;
          err_d    = 1'b0;
          st_d     = ST_CAPT;
        end
      end
      ST_CAPT: begin
        if (mode_cur == MODE_NORMAL) begin
          mode_wr    = 1'b1;
          mode_wdata = MODE_SLOW;
          parked_d   = 1'b1;
        end
        st_d = ST_RST_ON;
      end
      ST_RST_ON: begin
        rst_d = 1'b1;
        st_d  = ST_LOAD;
      end
      ST_LOAD: begin
        wr   = 1'b1;
        st_d = ST_RST_OFF;
      end
      ST_RST_OFF: begin
        rst_d     = 1'b0;
        tmr_start = 1'b1;
        poll_clr  = 1'b1;
        st_d      = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_expired) st_d = ST_POLL;
      end
      ST_POLL: begin
        poll_active = 1'b1;
        if (poll_hit) begin
          st_d = parked_q ? ST_UNPARK : ST_FIN;
        end else if (poll_expire) begin
          err_d = 1'b1;
          if (!rb_q) begin
            roll = 1'b1;
            rb_d = 1'b1;
            st_d = ST_RST_ON;
          end else begin
            st_d = parked_q ? ST_UNPARK : ST_FIN;
          end
        end
      end
      ST_UNPARK: begin
        mode_wr    = 1'b1;
        mode_wdata = MODE_NORMAL;
        st_d       = ST_FIN;
      end
      ST_FIN: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      parked_q <= 1'b0;
      rb_q     <= 1'b0;
      err_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      parked_q <= parked_d;
      rb_q     <= rb_d;
      err_q    <= err_d;
      rst_q    <= rst_d;
    end
  end

  assign pll_rst = rst_q;
  assign busy    = (st_q != ST_IDLE);
  assign err     = err_q;

  AST_PARK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == MODE_SLOW) |=> parked_q) else $error("park not recorded"); // R1
  AST_UNPARK_NEEDS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == MODE_NORMAL) |-> parked_q) else $error("unpark without park"); // R8
  AST_SINGLE_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_expire && rb_q) |=> (st_q != ST_RST_ON)) else $error("second rollback"); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy) else $error("done while idle"); // R9
  AST_ROLL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> err_q) else $error("rollback without error"); // R6
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int NR_W       = 6,
  parameter int NO_W       = 4,
  parameter int NF_W       = 13,
  parameter int NB_W       = 12,
  parameter int CYC_PER_US = 125,
  parameter int LOCK_LIMIT = 24000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [NR_W-1:0] req_nr,
  input  logic [NO_W-1:0] req_no,
  input  logic [NF_W-1:0] req_nf,
  input  logic [NB_W-1:0] req_nb,
  input  logic [1:0]      mode_cur,
  input  logic            lock,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            mode_wr,
  output logic [1:0]      mode_wdata,
  output logic            pll_rst,
  output logic [NR_W-1:0] div_nr,
  output logic [NO_W-1:0] div_no,
  output logic [NF_W-1:0] div_nf,
  output logic [NB_W-1:0] div_nb
);
  localparam int PROD_W = NR_W + 10;
  localparam int US_W   = $clog2((((2 ** NR_W) * 500) / 24) + 2);

  logic capture, roll, wr, tmr_start, poll_clr, poll_active;
  logic tmr_expired, poll_hit, poll_expire;
  logic [NR_W-1:0] tgt_nr;
  logic [NO_W-1:0] tgt_no;
  logic [NF_W-1:0] tgt_nf;
  logic [NB_W-1:0] tgt_nb;
  logic [PROD_W-1:0] nr_prod;
  logic [US_W-1:0]   dly_us;

  pllseq_field #(.W(NR_W)) u_nr (
    .clk(clk), .rst_n(rst_n), .capture(capture), .roll(roll), .wr(wr),
    .req_val(req_nr), .tgt(tgt_nr), .div_q(div_nr));
  pllseq_field #(.W(NO_W)) u_no (
    .clk(clk), .rst_n(rst_n), .capture(capture), .roll(roll), .wr(wr),
    .req_val(req_no), .tgt(tgt_no), .div_q(div_no));
  pllseq_field #(.W(NF_W)) u_nf (
    .clk(clk), .rst_n(rst_n), .capture(capture), .roll(roll), .wr(wr),
    .req_val(req_nf), .tgt(tgt_nf), .div_q(div_nf));
  pllseq_field #(.W(NB_W)) u_nb (
    .clk(clk), .rst_n(rst_n), .capture(capture), .roll(roll), .wr(wr),
    .req_val(req_nb), .tgt(tgt_nb), .div_q(div_nb));

  // Settle time in microseconds from the reference divider being programmed
  always_comb begin
    nr_prod = PROD_W'(tgt_nr) * PROD_W'(500);
    dly_us  = US_W'(nr_prod / PROD_W'(24)) + US_W'(1);
  end

  pllseq_us_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .dly_us(dly_us),
    .expired(tmr_expired));

  pllseq_lock_poll #(.LOCK_LIMIT(LOCK_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .active(poll_active),
    .lock(lock), .hit(poll_hit), .expire(poll_expire));

  pllseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_cur(mode_cur),
    .tmr_expired(tmr_expired), .poll_hit(poll_hit), .poll_expire(poll_expire),
    .capture(capture), .roll(roll), .wr(wr), .tmr_start(tmr_start),
    .poll_clr(poll_clr), .poll_active(poll_active), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .pll_rst(pll_rst), .busy(busy), .done(done),
    .err(err));

  logic [NR_W+NO_W+NF_W+NB_W-1:0] fld_all;
  assign fld_all = {div_nr, div_no, div_nf, div_nb};

  AST_FIELDS_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_all != $past(fld_all)) |-> (pll_rst && $past(pll_rst))) else $error("divider changed outside reset"); // R2
  AST_RESET_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> busy) else $error("pll reset while idle"); // R2
endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
  localparam int CYC = 4;
  localparam int LIM = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_nr = '0;
  logic [3:0] req_no = '0;
  logic [12:0] req_nf = '0;
  logic [11:0] req_nb = '0;
  logic [1:0] mux_mode;
  logic lock;
  logic busy, done, err, mode_wr, pll_rst;
  logic [1:0] mode_wdata;
  logic [5:0] div_nr;
  logic [3:0] div_no;
  logic [12:0] div_nf;
  logic [11:0] div_nb;

  int n_chk = 0;
  int n_err = 0;
  int lock_mode = 1;       // 0 never, 1 always, 2 when old values loaded
  logic [5:0] old_nr = '0;
  logic [3:0] old_no = '0;
  logic [12:0] old_nf = '0;
  logic [11:0] old_nb = '0;
  logic preset_en = 1'b0;
  logic [1:0] preset_val = 2'd0;

  // measurements of the last run
  int rises, fall_to_done, fall_to_rise2, slow_wr, norm_wr, stray, busy_gap;
  logic err_at_done;
  bit finished = 0;

  always #4 clk = ~clk;

  pll_reprog_seq #(.CYC_PER_US(CYC), .LOCK_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nr(req_nr),
    .req_no(req_no), .req_nf(req_nf), .req_nb(req_nb), .mode_cur(mux_mode),
    .lock(lock), .busy(busy), .done(done), .err(err), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .pll_rst(pll_rst), .div_nr(div_nr),
    .div_no(div_no), .div_nf(div_nf), .div_nb(div_nb));

  // clock selector model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mux_mode <= 2'd1;
    else if (mode_wr) mux_mode <= mode_wdata;
    else if (preset_en) mux_mode <= preset_val;
  end

  always_comb begin
    case (lock_mode)
      0: lock = 1'b0;
      1: lock = 1'b1;
      default: lock = !pll_rst && div_nr == old_nr && div_no == old_no &&
                      div_nf == old_nf && div_nb == old_nb;
    endcase
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int dly(input int nr);
    return ((nr * 500) / 24 + 1) * CYC;
  endfunction

  task automatic set_mux(input logic [1:0] m);
    @(negedge clk);
    preset_val = m;
    preset_en  = 1'b1;
    @(negedge clk);
    preset_en  = 1'b0;
  endtask

  task automatic run_req(input int nr, input int no, input int nf, input int nb,
                         input bit poke);
    int t0, cyc;
    bit prev_rst, got;
    logic [34:0] prev_f;
    rises = 0; fall_to_done = -1; fall_to_rise2 = -1; slow_wr = 0; norm_wr = 0;
    stray = 0; busy_gap = 0; err_at_done = 1'b0; got = 0; t0 = 0; cyc = 0;
    @(negedge clk);
    req_nr = 6'(nr); req_no = 4'(no); req_nf = 13'(nf); req_nb = 12'(nb);
    req_valid = 1'b1;
    prev_rst = pll_rst;
    prev_f = {div_nr, div_no, div_nf, div_nb};
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      cyc++;
      if (poke && i == 10) begin
        req_valid = 1'b1; req_nr = 6'd9; req_no = 4'd9; req_nf = 13'd9; req_nb = 12'd9;
      end else begin
        req_valid = 1'b0;
      end
      if (mode_wr && mode_wdata == 2'd0) slow_wr++;
      if (mode_wr && mode_wdata == 2'd1) norm_wr++;
      if ({div_nr, div_no, div_nf, div_nb} != prev_f && !pll_rst) stray++;
      if (pll_rst && !prev_rst) begin
        rises++;
        if (rises == 2) fall_to_rise2 = cyc - t0;
      end
      if (!pll_rst && prev_rst) t0 = cyc;
      if (!busy) busy_gap++;
      prev_rst = pll_rst;
      prev_f = {div_nr, div_no, div_nf, div_nb};
      if (done) begin
        fall_to_done = cyc - t0;
        err_at_done = err;
        got = 1;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(got, "R9 done reached", int'(got), 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err, "R10 status idle", int'({busy, done, err}), 0);
    chk(!pll_rst && !mode_wr, "R10 reset and mode strobe low", int'({pll_rst, mode_wr}), 0);
    chk({div_nr, div_no, div_nf, div_nb} == '0, "R10 dividers zero",
        int'({div_nr, div_no, div_nf, div_nb}), 0);
  endtask

  task automatic t_parked;
    lock_mode = 1;
    set_mux(2'd1);
    run_req(3, 2, 40, 20, 0);
    chk(div_nr == 6'd2 && div_no == 4'd1, "R3 nr/no minus one", int'({div_nr, div_no}), int'({6'd2, 4'd1}));
    chk(div_nf == 13'd39 && div_nb == 12'd19, "R3 nf/nb minus one", int'({div_nf, div_nb}), int'({13'd39, 12'd19}));
    chk(fall_to_done == dly(3) + 3, "R4 parked settle timing", fall_to_done, dly(3) + 3);
    chk(slow_wr == 1, "R1 park write", slow_wr, 1);
    chk(norm_wr == 1 && mux_mode == 2'd1, "R8 restore normal", norm_wr, 1);
    chk(stray == 0 && rises == 1, "R2 writes inside reset", stray, 0);
    chk(busy_gap == 0, "R9 busy held", busy_gap, 0);
    chk(!err_at_done, "R6 no error on lock", int'(err_at_done), 0);
  endtask

  task automatic t_unparked;
    lock_mode = 1;
    set_mux(2'd0);
    run_req(1, 4, 100, 9, 1);
    chk(fall_to_done == dly(1) + 2, "R4 unparked settle timing", fall_to_done, dly(1) + 2);
    chk(slow_wr == 0, "R1 no park from slow", slow_wr, 0);
    chk(norm_wr == 0 && mux_mode == 2'd0, "R8 no restore when not parked", norm_wr, 0);
    chk(div_nr == 6'd0 && div_nf == 13'd99, "R9 busy request ignored", int'(div_nf), 99);
    repeat (4) @(negedge clk);
    chk(!busy, "R9 no second sequence", int'(busy), 0);
    old_nr = div_nr; old_no = div_no; old_nf = div_nf; old_nb = div_nb;
  endtask

  task automatic t_rollback_ok;
    lock_mode = 2;
    set_mux(2'd1);
    run_req(5, 2, 200, 30, 0);
    chk(fall_to_rise2 == dly(5) + LIM + 2, "R5 poll limit timing", fall_to_rise2, dly(5) + LIM + 2);
    chk(rises == 2, "R6 second pass run", rises, 2);
    chk(div_nf == old_nf && div_nb == old_nb && div_nr == old_nr && div_no == old_no,
        "R6 old values restored", int'(div_nf), int'(old_nf));
    chk(err_at_done, "R6 error flag", int'(err_at_done), 1);
    chk(fall_to_done == dly(1) + 3, "R4 rollback settle uses old NR", fall_to_done, dly(1) + 3);
    chk(norm_wr == 1 && slow_wr == 1 && mux_mode == 2'd1, "R8 restore after rollback", norm_wr, 1);
  endtask

  task automatic t_double_timeout;
    lock_mode = 0;
    set_mux(2'd1);
    run_req(2, 3, 77, 5, 0);
    chk(rises == 2, "R7 only one rollback", rises, 2);
    chk(err_at_done, "R7 error after double timeout", int'(err_at_done), 1);
    chk(div_nf == old_nf && div_nr == old_nr, "R7 old values left", int'(div_nf), int'(old_nf));
    chk(fall_to_done == dly(1) + LIM + 2, "R7 finish timing", fall_to_done, dly(1) + LIM + 2);
    chk(mux_mode == 2'd1 && norm_wr == 1, "R8 restore after double timeout", norm_wr, 1);
    chk(stray == 0, "R2 no stray writes", stray, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_parked();
    t_unparked();
    t_rollback_ok();
    t_double_timeout();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule